// File: doc/BRIEF.md
# Bus-Width Matching Adapter with Byte Reordering

This block sits between a 36-bit queue word and an external port that can move 36, 18 or 9 bits at a time. The 36-bit word is handled as four 9-bit lanes, where each lane is eight data bits plus a parity bit. The adapter treats parity bits as ordinary data and never checks them.

On the write side, narrow beats from the port are collected into one full word. That word is handed to the queue with a single-cycle strobe. On the read side, the word the queue presents is split into successive narrow beats. The queue is told to advance only when the last beat of the word is taken.

Three static configuration inputs set the behaviour. One picks the lane order, big- or little-endian. One picks the port width. One picks a lane-swap mode for the whole word. Any swap mode works with any port width.

Top module: `bytelane_bus_adapter`

## Requirements
- R1: After reset `fw_valid` is 0. Both beat counters start at the first beat of a word.
- R2: Width code `cfg_size` = 00 selects 36-bit beats. Each accepted write beat makes `fw_valid` high on the following cycle, with `fw_data` = swap(`wp_data`).
- R3: Width code 01 selects 18-bit beats on `wp_data[17:0]`. Two beats form a word. `fw_valid` pulses only in the cycle after the second beat.
- R4: Width code 10 selects 9-bit beats on `wp_data[8:0]`. Four beats form a word. `fw_valid` pulses only in the cycle after the fourth beat.
- R5: With `cfg_little` = 0 (big-endian), the first beat carries the most significant lanes (bits 35 downward). With `cfg_little` = 1, the first beat carries the least significant lanes.
- R6: Swap code `cfg_swap` applies to the whole word, with lane 3 at bits 35:27 and lane 0 at bits 8:0. It is applied after packing on writes and before splitting on reads. The codes are: 00 none; 01 lanes 3,2,1,0 become 0,1,2,3; 10 the two 18-bit halves are exchanged; 11 the lanes inside each half are exchanged.
- R7: In 36-bit mode `rp_data` = swap(`fr_data`), and every `rp_req` asserts `fr_pop` in the same cycle.
- R8: In 18-bit mode `rp_data[17:0]` carries the current half in the R5 order and `rp_data[35:18]` is 0. `fr_pop` is asserted only with the second `rp_req` of a word.
- R9: In 9-bit mode `rp_data[8:0]` carries the current lane in the R5 order and `rp_data[35:9]` is 0. `fr_pop` is asserted only with the fourth `rp_req` of a word.
- R10: Cycles with `wp_valid` or `rp_req` low do not advance a beat counter and do not produce `fw_valid`.
- R11: Width code 11 behaves as 36-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Port width: 00 = 36, 01 = 18, 10 = 9, 11 = 36 |
| cfg_little | input | 1 | 1 = little-endian beat order |
| cfg_swap | input | 2 | Lane-swap mode |
| wp_valid | input | 1 | Write beat present |
| wp_data | input | 36 | Write beat data, narrow beats on the low bits |
| fw_valid | output | 1 | Packed word strobe to the queue |
| fw_data | output | 36 | Packed word |
| rp_req | input | 1 | Read beat taken by the port |
| rp_data | output | 36 | Read beat data, narrow beats on the low bits |
| fr_data | input | 36 | Word presented by the queue |
| fr_pop | output | 1 | Advance the queue to its next word |

## Verification
The assertions assume that the three configuration inputs stay fixed between reset and the end of use. They also assume that `fr_data` holds steady for all beats of one word. The bench changes the configuration only while reset is applied, and it keeps `fr_data` constant across each word. The bench asserts `rp_req` only when a word is assumed to be available, so the pop pacing the assertions check comes only from the beat count.

// File: rtl/bytelane_bus_adapter.sv
module bytelane_bus_adapter #(
  parameter int BYTE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_size,
  input  logic                  cfg_little,
  input  logic [1:0]            cfg_swap,
  input  logic                  wp_valid,
  input  logic [4*BYTE_W-1:0]   wp_data,
  output logic                  fw_valid,
  output logic [4*BYTE_W-1:0]   fw_data,
  input  logic                  rp_req,
  output logic [4*BYTE_W-1:0]   rp_data,
  input  logic [4*BYTE_W-1:0]   fr_data,
  output logic                  fr_pop
);
  localparam int WORD_W = 4 * BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] w, input logic [1:0] m);
    logic [BYTE_W-1:0] b3, b2, b1, b0;
    {b3, b2, b1, b0} = w;
    case (m)
      2'b01:   lane_swap = {b0, b1, b2, b3};
      2'b10:   lane_swap = {b1, b0, b3, b2};
      2'b11:   lane_swap = {b2, b3, b0, b1};
      default: lane_swap = w;
    endcase
  endfunction

  wire mode_half = (cfg_size == 2'b01);
  wire mode_byte = (cfg_size == 2'b10);
  wire mode_wide = !mode_half && !mode_byte;

  logic [1:0]        wr_cnt, rd_cnt;
  logic [WORD_W-1:0] acc, merged;

  wire wr_last = mode_wide || (mode_half && wr_cnt[0]) || (mode_byte && wr_cnt == 2'd3);
  wire rd_last = mode_wide || (mode_half && rd_cnt[0]) || (mode_byte && rd_cnt == 2'd3);

  wire       wr_hpos = cfg_little ? wr_cnt[0] : ~wr_cnt[0];
  wire [1:0] wr_bpos = cfg_little ? wr_cnt : ~wr_cnt;
  wire       rd_hpos = cfg_little ? rd_cnt[0] : ~rd_cnt[0];
  wire [1:0] rd_bpos = cfg_little ? rd_cnt : ~rd_cnt;

  always_comb begin
    merged = acc;
    if (mode_wide)      merged = wp_data;
    else if (mode_half) merged[int'(wr_hpos)*HALF_W +: HALF_W] = wp_data[HALF_W-1:0];
    else                merged[int'(wr_bpos)*BYTE_W +: BYTE_W] = wp_data[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt   <= '0;
      acc      <= '0;
      fw_valid <= 1'b0;
      fw_data  <= '0;
    end else begin
      fw_valid <= 1'b0;
      if (wp_valid) begin
        acc <= merged;
        if (wr_last) begin
          wr_cnt   <= '0;
          fw_valid <= 1'b1;
          fw_data  <= lane_swap(merged, cfg_swap);
        end else begin
          wr_cnt <= wr_cnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_cnt <= '0;
    else if (rp_req) rd_cnt <= rd_last ? 2'd0 : rd_cnt + 2'd1;
  end

  wire [WORD_W-1:0] rd_sw = lane_swap(fr_data, cfg_swap);

  always_comb begin
    rp_data = '0;
    if (mode_wide)      rp_data = rd_sw;
    else if (mode_half) rp_data[HALF_W-1:0] = rd_sw[int'(rd_hpos)*HALF_W +: HALF_W];
    else                rp_data[BYTE_W-1:0] = rd_sw[int'(rd_bpos)*BYTE_W +: BYTE_W];
  end

  assign fr_pop = rp_req && rd_last;

  AST_STROBE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> $past(wp_valid)); // R10
  AST_WIDE_WRITE_EACH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_valid && mode_wide) |=> fw_valid); // R2
  AST_NARROW_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && !mode_wide) |-> !$past(fw_valid)); // R3
  AST_WIDE_POP_EACH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && mode_wide) |-> fr_pop); // R7
  AST_NARROW_POP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && fr_pop && !mode_wide) |=> !fr_pop); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_byte |-> (rp_data[WORD_W-1:BYTE_W] == '0)); // R9
endmodule

// File: tb/bytelane_bus_adapter_tb.sv
module bytelane_bus_adapter_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] cfg_size = 0;
  logic cfg_little = 0;
  logic [1:0] cfg_swap = 0;
  logic wp_valid = 0;
  logic [35:0] wp_data = 0;
  logic fw_valid;
  logic [35:0] fw_data;
  logic rp_req = 0;
  logic [35:0] rp_data;
  logic [35:0] fr_data = 0;
  logic fr_pop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bytelane_bus_adapter u_dut (.*);

  function automatic logic [35:0] ref_swap(input logic [35:0] w, input logic [1:0] m);
    logic [8:0] l [4];
    for (int i = 0; i < 4; i++) l[i] = w[i*9 +: 9];
    case (m)
      2'b01: return {l[0], l[1], l[2], l[3]};
      2'b10: return {l[1], l[0], l[3], l[2]};
      2'b11: return {l[2], l[3], l[0], l[1]};
      default: return w;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sz, input logic lit, input logic [1:0] sw);
    @(negedge clk);
    rst_n = 0; cfg_size = sz; cfg_little = lit; cfg_swap = sw; wp_valid = 0; rp_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic test_reset();
    do_reset(2'b10, 0, 0);
    check(fw_valid == 0, "R1", 36'(fw_valid), 0);
    wp_valid = 1; wp_data = 36'h1AA;
    @(negedge clk); wp_valid = 0;
    check(fw_valid == 0, "R1", 36'(fw_valid), 0);
  endtask

  task automatic send_word(input logic [1:0] sz, input logic [35:0] beats [4], input int n);
    for (int k = 0; k < n; k++) begin
      wp_valid = 1; wp_data = beats[k];
      @(negedge clk);
      if (k < n-1) check(fw_valid == 0, sz == 2'b01 ? "R3" : "R4", 36'(fw_valid), 0);
    end
    wp_valid = 0;
  endtask

  task automatic test_write(input logic [1:0] sz, input string req);
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++) begin
        logic [35:0] w, b [4];
        int n;
        do_reset(sz, e[0], s[1:0]);
        w = {9'h1A3, 9'h0B4, 9'h1C5, 9'h0D6} ^ {4{s[1:0], e[0], 6'h15}};
        n = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
        for (int k = 0; k < 4; k++) b[k] = 0;
        if (n == 1) b[0] = w;
        else if (n == 2) begin
          b[0] = e ? 36'(w[17:0]) : 36'(w[35:18]);
          b[1] = e ? 36'(w[35:18]) : 36'(w[17:0]);
        end else
          for (int k = 0; k < 4; k++) b[k] = 36'(w[(e ? k : 3-k)*9 +: 9]);
        send_word(sz, b, n);
        check(fw_valid == 1, req, 36'(fw_valid), 1);
        check(fw_data == ref_swap(w, s[1:0]), e ? "R5/R6 little" : "R5/R6 big", fw_data, ref_swap(w, s[1:0]));
        @(negedge clk);
        check(fw_valid == 0, req, 36'(fw_valid), 0);
      end
  endtask

  task automatic test_idle();
    logic [35:0] w = 36'h9_8765_4321;
    do_reset(2'b10, 0, 2'b00);
    for (int k = 0; k < 2; k++) begin
      wp_valid = 1; wp_data = 36'(w[(3-k)*9 +: 9]); @(negedge clk);
    end
    wp_valid = 0;
    repeat (3) begin
      @(negedge clk);
      check(fw_valid == 0, "R10", 36'(fw_valid), 0);
    end
    for (int k = 2; k < 4; k++) begin
      wp_valid = 1; wp_data = 36'(w[(3-k)*9 +: 9]); @(negedge clk);
    end
    wp_valid = 0;
    check(fw_valid == 1 && fw_data == w, "R10", fw_data, w);
  endtask

  task automatic test_read(input logic [1:0] sz, input string req);
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++) begin
        logic [35:0] w, sw, exp;
        int n;
        do_reset(sz, e[0], s[1:0]);
        w = 36'h3_5A6B_7C8D ^ {4{s[1:0], e[0], 6'h2A}};
        sw = ref_swap(w, s[1:0]);
        n = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
        fr_data = w;
        for (int k = 0; k < n; k++) begin
          rp_req = 1;
          #1;
          if (n == 1) exp = sw;
          else if (n == 2) exp = 36'(sw[(e ? k : 1-k)*18 +: 18]);
          else exp = 36'(sw[(e ? k : 3-k)*9 +: 9]);
          check(rp_data == exp, req, rp_data, exp);
          check(fr_pop == (k == n-1), req, 36'(fr_pop), 36'(k == n-1));
          @(negedge clk);
        end
        rp_req = 0;
        #1;
        check(fr_pop == 0, "R10", 36'(fr_pop), 0);
        if (n > 1) begin
          @(negedge clk);
          rp_req = 1; #1;
          exp = (n == 2) ? 36'(sw[(e ? 0 : 1)*18 +: 18]) : 36'(sw[(e ? 0 : 3)*9 +: 9]);
          check(rp_data == exp && fr_pop == 0, "R10", rp_data, exp);
          @(negedge clk); rp_req = 0;
        end
      end
  endtask

  task automatic test_size11();
    logic [35:0] b [4];
    b[0] = 36'hF_0F0F_0F0F; b[1] = 0; b[2] = 0; b[3] = 0;
    do_reset(2'b11, 0, 2'b01);
    send_word(2'b11, b, 1);
    check(fw_valid == 1 && fw_data == ref_swap(b[0], 2'b01), "R11", fw_data, ref_swap(b[0], 2'b01));
    fr_data = 36'h1_2345_6789; rp_req = 1; #1;
    check(rp_data == ref_swap(fr_data, 2'b01) && fr_pop, "R11", rp_data, ref_swap(fr_data, 2'b01));
    @(negedge clk); rp_req = 0;
  endtask

  initial begin
    test_reset();
    test_write(2'b00, "R2");
    test_write(2'b01, "R3");
    test_write(2'b10, "R4");
    test_idle();
    test_read(2'b00, "R7");
    test_read(2'b01, "R8");
    test_read(2'b10, "R9");
    test_size11();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule